// File: doc/BRIEF.md
# Flash Command Sequence Guard

This block polices the order in which software issues commands to an embedded flash controller. A command takes three writes. First a data word goes to an even address in the array space. Next a command code goes to the command register. Last, a write of 1 to the go bit of the status register launches the command. Any step that breaks the order, or that the current security or protection settings forbid, ends the sequence and raises one of two sticky error flags. The block also holds a small execution engine. It has one running slot and one waiting slot, and a busy timer stands in for the program and erase algorithms, so a second command can be queued while the first one runs.

The outputs are a buffer-empty flag, a command-complete flag, the two error flags, a read-invalid indication for array reads, and a one-cycle launch pulse. The pulse carries the latched address and command code to the rest of the controller. While either error flag is set, array writes and command writes are ignored until software clears the flag by writing 1 to its clear bit.

Top module: `fcs_guard`

## Requirements
- R1: After reset, buf_empty and cmd_done are 1, and acc_err, prot_viol, launch and rd_invalid are 0.
- R2: An array word write to an even address, then a command write with a supported code, then a status write with bit 0 (go) set, raises launch for one cycle with the latched address and code. Supported codes are program 8'h21, sector erase 8'h42, mass erase 8'h43, compress 8'h05 and erase abort 8'h47. When the engine was idle, cmd_done drops in that same cycle and returns to 1 after BUSY_CYC cycles.
- R3: An array write while div_ready is 0 sets acc_err and ends the sequence.
- R4: An array write with byte_wr at 1, or to an odd address, sets acc_err.
- R5: Starting a sequence while a compress or erase-abort operation is running sets acc_err.
- R6: A second array write in one sequence, a second command write in one sequence, or an unsupported command code sets acc_err.
- R7: After the word write, a write to any register other than the command register (reg_sel 1) sets acc_err. After the command write, a write to any register other than the status register (reg_sel 0) sets acc_err.
- R8: A status write with go at 0 after the command write sets acc_err. Register and array reads never change either error flag.
- R9: With secure_en at 1 and secure_origin at 0, any command code other than mass erase sets acc_err.
- R10: Launching erase abort while a sector erase runs cuts the erase short and sets acc_err. stop_req during a program or erase clears the running and waiting commands (cmd_done and buf_empty go to 1) and sets acc_err.
- R11: prot_viol is set by a program or sector erase aimed at a protected region, where the region is addr[AW-1:AW-2] indexing prot_en. It is also set by a mass erase while any prot_en bit is 1. Either case ends the sequence.
- R12: rd_invalid is 1 during an array read while cmd_done is 0. Such a read sets no flag.
- R13: While either flag is set, array and command writes are ignored. Status bit 1 clears prot_viol and status bit 2 clears acc_err. Each bit clears only its own flag.
- R14: A command launched while another runs waits in the engine with buf_empty at 0. A new array write is ignored until the waiting command starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| arr_sel | input | 1 | 1: access targets the array space; 0: register space |
| byte_wr | input | 1 | Write is byte-wide |
| addr | input | AW | Array address |
| reg_sel | input | 2 | Register select: 0 status, 1 command, 2 and 3 other |
| wdata | input | 8 | Write data |
| div_ready | input | 1 | Clock divider has been set up |
| secure_en | input | 1 | Security mode active |
| secure_origin | input | 1 | Current access comes from a trusted origin |
| prot_en | input | NREG | Per-region protection enables |
| stop_req | input | 1 | Stop-mode entry request |
| buf_empty | output | 1 | Command buffer can take a new sequence |
| cmd_done | output | 1 | No command is running or waiting |
| acc_err | output | 1 | Access-error flag |
| prot_viol | output | 1 | Protection-violation flag |
| launch | output | 1 | One-cycle command launch pulse |
| launch_addr | output | AW | Address of the launched command |
| launch_cmd | output | 8 | Code of the launched command |
| rd_invalid | output | 1 | Array read data is not valid |

## Verification
The assertions assume that only one bus strobe is meaningful per cycle. A cycle with neither a write nor a stop request must then leave the flags untouched. They also assume that the only route to a falling cmd_done is a launch into an idle engine. The stimulus drives at most one write or read per cycle, with an idle cycle between accesses. It changes the configuration inputs (div_ready, secure_en, secure_origin, prot_en) only while no sequence is partly written. It pulses stop_req for one cycle, and only while a write is not being made.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] CODE_PROG  = 8'h21;
    localparam logic [CODE_W-1:0] CODE_SECT  = 8'h42;
    localparam logic [CODE_W-1:0] CODE_MASS  = 8'h43;
    localparam logic [CODE_W-1:0] CODE_COMP  = 8'h05;
    localparam logic [CODE_W-1:0] CODE_ABORT = 8'h47;

    localparam logic [1:0] SEL_STAT = 2'd0;
    localparam logic [1:0] SEL_CMD  = 2'd1;

    localparam int STAT_GO    = 0;
    localparam int STAT_PVCLR = 1;
    localparam int STAT_ACCLR = 2;

    typedef enum logic [1:0] {SQ_IDLE, SQ_WORD, SQ_CMD} seq_st_e;
    typedef enum logic [2:0] {OP_PROG, OP_SECT, OP_MASS, OP_COMP, OP_ABORT} op_e;

    function automatic logic code_ok(input logic [CODE_W-1:0] c);
        return c inside {CODE_PROG, CODE_SECT, CODE_MASS, CODE_COMP, CODE_ABORT};
    endfunction

    function automatic op_e code_op(input logic [CODE_W-1:0] c);
        case (c)
            CODE_SECT:  return OP_SECT;
            CODE_MASS:  return OP_MASS;
            CODE_COMP:  return OP_COMP;
            CODE_ABORT: return OP_ABORT;
            default:    return OP_PROG;
        endcase
    endfunction
endpackage

// File: rtl/fcs_engine.sv
module fcs_engine
    import fcs_pkg::*;
#(
    parameter int BUSY_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic go,
    input  op_e  go_op,
    output logic busy_o,
    output op_e  op_o,
    output logic pend_o
);
    localparam int TW = $clog2(BUSY_CYC + 1);
    localparam logic [TW-1:0] TLOAD = TW'(BUSY_CYC);

    typedef struct packed {
        logic          busy;
        op_e           op;
        logic [TW-1:0] tmr;
        logic          pend;
        op_e           pop;
    } eng_s;

    eng_s q, d;

    always_comb begin
        d = q;
        if (kill) begin
            d.busy = 1'b0;
            d.pend = 1'b0;
        end else begin
            if (q.busy) begin
                if (q.tmr == TW'(1)) d.busy = 1'b0;
                else                 d.tmr  = q.tmr - TW'(1);
            end
            if (go && go_op == OP_ABORT && q.busy && q.op == OP_SECT) begin
                d.busy = 1'b1;
                d.op   = OP_ABORT;
                d.tmr  = TLOAD;
            end else if (go) begin
                if (!d.busy) begin
                    d.busy = 1'b1;
                    d.op   = go_op;
                    d.tmr  = TLOAD;
                end else begin
                    d.pend = 1'b1;
                    d.pop  = go_op;
                end
            end else if (q.pend && !d.busy) begin
                d.busy = 1'b1;
                d.op   = q.pop;
                d.tmr  = TLOAD;
                d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, op: OP_PROG, tmr: '0, pend: 1'b0, pop: OP_PROG};
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;
    assign op_o   = q.op;
    assign pend_o = q.pend;
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
    import fcs_pkg::*;
#(
    parameter int AW   = 12,
    parameter int NREG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              arr_sel,
    input  logic              byte_wr,
    input  logic [AW-1:0]     addr,
    input  logic [1:0]        reg_sel,
    input  logic [CODE_W-1:0] wdata,
    input  logic              div_ready,
    input  logic              secure_en,
    input  logic              secure_origin,
    input  logic [NREG-1:0]   prot_en,
    input  logic              stop_req,
    input  logic              eng_busy,
    input  op_e               eng_op,
    input  logic              eng_pend,
    output logic              go,
    output op_e               go_op,
    output logic              kill,
    output logic              acc_err,
    output logic              prot_viol,
    output logic              launch,
    output logic [AW-1:0]     launch_addr,
    output logic [CODE_W-1:0] launch_cmd
);
    localparam int RW = $clog2(NREG);

    typedef struct packed {
        seq_st_e           st;
        logic              acc;
        logic              pv;
        logic [AW-1:0]     addr;
        logic [CODE_W-1:0] cmd;
        op_e               op;
        logic              launch;
        logic [AW-1:0]     laddr;
        logic [CODE_W-1:0] lcmd;
    } seq_s;

    seq_s q, d;

    logic          flag_any;
    logic          busy_slow;
    logic          busy_hv;
    logic [RW-1:0] region;
    op_e           new_op;

    always_comb begin
        flag_any  = q.acc || q.pv;
        busy_slow = eng_busy && (eng_op == OP_COMP || eng_op == OP_ABORT);
        busy_hv   = eng_busy && (eng_op == OP_PROG || eng_op == OP_SECT || eng_op == OP_MASS);
        region    = q.addr[AW-1 -: RW];
        new_op    = code_op(wdata);

        d        = q;
        d.launch = 1'b0;
        go       = 1'b0;
        go_op    = q.op;
        kill     = 1'b0;

        if (stop_req && busy_hv) begin
            kill  = 1'b1;
            d.acc = 1'b1;
            d.st  = SQ_IDLE;
        end else if (wr_en && arr_sel) begin
            if (!flag_any) begin
                if (q.st != SQ_IDLE) begin
                    d.acc = 1'b1;
                    d.st  = SQ_IDLE;
                end else if (!div_ready || byte_wr || addr[0] || busy_slow) begin
                    d.acc = 1'b1;
                end else if (!eng_pend) begin
                    d.addr = addr;
                    d.st   = SQ_WORD;
                end
            end
        end else if (wr_en) begin
            if (reg_sel == SEL_STAT) begin
                if (wdata[STAT_PVCLR]) d.pv  = 1'b0;
                if (wdata[STAT_ACCLR]) d.acc = 1'b0;
                if (q.st == SQ_WORD) begin
                    d.acc = 1'b1;
                    d.st  = SQ_IDLE;
                end else if (q.st == SQ_CMD) begin
                    d.st = SQ_IDLE;
                    if (wdata[STAT_GO]) begin
                        go       = 1'b1;
                        d.launch = 1'b1;
                        d.laddr  = q.addr;
                        d.lcmd   = q.cmd;
                        if (q.op == OP_ABORT && eng_busy && eng_op == OP_SECT) d.acc = 1'b1;
                    end else begin
                        d.acc = 1'b1;
                    end
                end
            end else if (reg_sel == SEL_CMD) begin
                if (!flag_any && q.st == SQ_CMD) begin
                    d.acc = 1'b1;
                    d.st  = SQ_IDLE;
                end else if (!flag_any && q.st == SQ_WORD) begin
                    d.st = SQ_IDLE;
                    if (!code_ok(wdata)) begin
                        d.acc = 1'b1;
                    end else if (secure_en && !secure_origin && wdata != CODE_MASS) begin
                        d.acc = 1'b1;
                    end else if ((new_op == OP_PROG || new_op == OP_SECT) && prot_en[region]) begin
                        d.pv = 1'b1;
                    end else if (new_op == OP_MASS && |prot_en) begin
                        d.pv = 1'b1;
                    end else begin
                        d.cmd = wdata;
                        d.op  = new_op;
                        d.st  = SQ_CMD;
                    end
                end
            end else if (q.st != SQ_IDLE) begin
                d.acc = 1'b1;
                d.st  = SQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, acc: 1'b0, pv: 1'b0, addr: '0, cmd: '0, op: OP_PROG,
                   launch: 1'b0, laddr: '0, lcmd: '0};
        end else begin
            q <= d;
        end
    end

    assign acc_err     = q.acc;
    assign prot_viol   = q.pv;
    assign launch      = q.launch;
    assign launch_addr = q.laddr;
    assign launch_cmd  = q.lcmd;
endmodule

// File: rtl/fcs_guard.sv
module fcs_guard
    import fcs_pkg::*;
#(
    parameter int AW       = 12,
    parameter int NREG     = 4,
    parameter int BUSY_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              arr_sel,
    input  logic              byte_wr,
    input  logic [AW-1:0]     addr,
    input  logic [1:0]        reg_sel,
    input  logic [CODE_W-1:0] wdata,
    input  logic              div_ready,
    input  logic              secure_en,
    input  logic              secure_origin,
    input  logic [NREG-1:0]   prot_en,
    input  logic              stop_req,
    output logic              buf_empty,
    output logic              cmd_done,
    output logic              acc_err,
    output logic              prot_viol,
    output logic              launch,
    output logic [AW-1:0]     launch_addr,
    output logic [CODE_W-1:0] launch_cmd,
    output logic              rd_invalid
);
    logic eng_busy, eng_pend, go, kill;
    op_e  eng_op, go_op;

    fcs_seq #(.AW(AW), .NREG(NREG)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .arr_sel(arr_sel), .byte_wr(byte_wr),
        .addr(addr), .reg_sel(reg_sel), .wdata(wdata), .div_ready(div_ready),
        .secure_en(secure_en), .secure_origin(secure_origin), .prot_en(prot_en),
        .stop_req(stop_req), .eng_busy(eng_busy), .eng_op(eng_op), .eng_pend(eng_pend),
        .go(go), .go_op(go_op), .kill(kill), .acc_err(acc_err), .prot_viol(prot_viol),
        .launch(launch), .launch_addr(launch_addr), .launch_cmd(launch_cmd)
    );

    fcs_engine #(.BUSY_CYC(BUSY_CYC)) u_eng (
        .clk(clk), .rst_n(rst_n), .kill(kill), .go(go), .go_op(go_op),
        .busy_o(eng_busy), .op_o(eng_op), .pend_o(eng_pend)
    );

    assign buf_empty  = !eng_pend;
    assign cmd_done   = !eng_busy && !eng_pend;
    assign rd_invalid = rd_en && arr_sel && !cmd_done;
endmodule

// File: rtl/fcs_guard_chk.sv
module fcs_guard_chk
    import fcs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       arr_sel,
    input logic [1:0] reg_sel,
    input logic       stop_req,
    input logic       cmd_done,
    input logic       acc_err,
    input logic       prot_viol,
    input logic       launch
);
    // R2: launch is a single-cycle pulse
    a_r2_launch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);

    // R2: cmd_done only falls when a command is launched
    a_r2_done_fall_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_done) |-> launch);

    // R13: no launch out of a cycle where a flag was set
    a_r13_no_launch_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> $past(!acc_err && !prot_viol));

    // R8: cycles without a write or stop leave both flags alone
    a_r8_quiet_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !stop_req) |=> ($stable(acc_err) && $stable(prot_viol)));

    // R11: prot_viol is raised only by a command register write
    a_r11_pv_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_viol) |-> $past(wr_en && !arr_sel && reg_sel == SEL_CMD));
endmodule

bind fcs_guard fcs_guard_chk u_chk (.*);

// File: tb/fcs_guard_tb_top.sv
module fcs_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 12;
    localparam int NREG = 4;
    localparam int BUSY = 16;

    localparam logic [7:0] C_PROG = 8'h21, C_SECT = 8'h42, C_MASS = 8'h43,
                           C_COMP = 8'h05, C_ABORT = 8'h47;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, rd_en = 0, arr_sel = 0, byte_wr = 0;
    logic [AW-1:0] addr = '0;
    logic [1:0] reg_sel = '0;
    logic [7:0] wdata = '0;
    logic div_ready = 0, secure_en = 0, secure_origin = 0, stop_req = 0;
    logic [NREG-1:0] prot_en = '0;
    logic buf_empty, cmd_done, acc_err, prot_viol, launch, rd_invalid;
    logic [AW-1:0] launch_addr;
    logic [7:0] launch_cmd;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcs_guard #(.AW(AW), .NREG(NREG), .BUSY_CYC(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .arr_sel(arr_sel),
        .byte_wr(byte_wr), .addr(addr), .reg_sel(reg_sel), .wdata(wdata),
        .div_ready(div_ready), .secure_en(secure_en), .secure_origin(secure_origin),
        .prot_en(prot_en), .stop_req(stop_req), .buf_empty(buf_empty), .cmd_done(cmd_done),
        .acc_err(acc_err), .prot_viol(prot_viol), .launch(launch), .launch_addr(launch_addr),
        .launch_cmd(launch_cmd), .rd_invalid(rd_invalid)
    );

    int n_vec = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";
    bit finished = 0;

    // behavioural reference
    int mst, macc, mpv, mlaunch, mb, mt, mp;
    int maddr, mcmd, mla, mlc, mop, mpo;
    int nst, nacc, npv, nb, nt, np, naddr, ncmd, nop, npo, nla, nlc, nl;
    int go, gop, kill, hv, slow;

    function automatic bit valid_code(int c);
        return c == C_PROG || c == C_SECT || c == C_MASS || c == C_COMP || c == C_ABORT;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; macc = 0; mpv = 0; mlaunch = 0; mb = 0; mt = 0; mp = 0;
            maddr = 0; mcmd = 0; mla = 0; mlc = 0; mop = 0; mpo = 0;
        end else begin
            nst = mst; nacc = macc; npv = mpv; naddr = maddr; ncmd = mcmd;
            nla = mla; nlc = mlc; nl = 0; go = 0; gop = mcmd;
            hv   = mb && (mop == C_PROG || mop == C_SECT || mop == C_MASS);
            slow = mb && (mop == C_COMP || mop == C_ABORT);
            kill = stop_req && hv;
            if (kill) begin
                nacc = 1; nst = 0;
            end else if (wr_en && arr_sel) begin
                if (!(macc || mpv)) begin
                    if (mst != 0) begin nacc = 1; nst = 0; end
                    else if (!div_ready || byte_wr || addr[0] || slow) nacc = 1;
                    else if (!mp) begin naddr = addr; nst = 1; end
                end
            end else if (wr_en && reg_sel == 0) begin
                if (wdata[1]) npv = 0;
                if (wdata[2]) nacc = 0;
                if (mst == 1) begin nacc = 1; nst = 0; end
                else if (mst == 2) begin
                    nst = 0;
                    if (wdata[0]) begin
                        go = 1; nl = 1; nla = maddr; nlc = mcmd;
                        if (mcmd == C_ABORT && mb && mop == C_SECT) nacc = 1;
                    end else nacc = 1;
                end
            end else if (wr_en && reg_sel == 1) begin
                if (!(macc || mpv) && mst == 2) begin nacc = 1; nst = 0; end
                else if (!(macc || mpv) && mst == 1) begin
                    nst = 0;
                    if (!valid_code(wdata)) nacc = 1;
                    else if (secure_en && !secure_origin && wdata != C_MASS) nacc = 1;
                    else if ((wdata == C_PROG || wdata == C_SECT) && prot_en[maddr >> (AW-2)]) npv = 1;
                    else if (wdata == C_MASS && prot_en != 0) npv = 1;
                    else begin ncmd = wdata; nst = 2; end
                end
            end else if (wr_en) begin
                if (mst != 0) begin nacc = 1; nst = 0; end
            end
            // engine
            nb = mb; nt = mt; np = mp; nop = mop; npo = mpo;
            if (kill) begin nb = 0; np = 0; end
            else begin
                if (mb) begin if (mt == 1) nb = 0; else nt = mt - 1; end
                if (go && gop == C_ABORT && mb && mop == C_SECT) begin nb = 1; nop = C_ABORT; nt = BUSY; end
                else if (go) begin
                    if (!nb) begin nb = 1; nop = gop; nt = BUSY; end
                    else begin np = 1; npo = gop; end
                end else if (mp && !nb) begin nb = 1; nop = mpo; nt = BUSY; np = 0; end
            end
            mst = nst; macc = nacc; mpv = npv; maddr = naddr; mcmd = ncmd;
            mla = nla; mlc = nlc; mlaunch = nl; mb = nb; mt = nt; mp = np; mop = nop; mpo = npo;
        end
    end

    // per-cycle comparison away from the clock edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit bad;
            bit exp_done;
            exp_done = !mb && !mp;
            bad = 0;
            n_vec++;
            if (buf_empty !== (mp == 0)) bad = 1;
            if (cmd_done !== exp_done) bad = 1;
            if (acc_err !== (macc != 0)) bad = 1;
            if (prot_viol !== (mpv != 0)) bad = 1;
            if (launch !== (mlaunch != 0)) bad = 1;
            if (mlaunch != 0 && (launch_addr !== AW'(mla) || launch_cmd !== 8'(mlc))) bad = 1;
            if (rd_invalid !== (rd_en && arr_sel && !exp_done)) bad = 1;
            if (bad) begin
                n_bad++;
                $display("FAIL %s cycle %0d: got be=%b cd=%b acc=%b pv=%b l=%b la=%h lc=%h ri=%b exp be=%b cd=%b acc=%0d pv=%0d l=%0d la=%h lc=%h",
                         cur_req, cyc, buf_empty, cmd_done, acc_err, prot_viol, launch, launch_addr,
                         launch_cmd, rd_invalid, mp == 0, exp_done, macc, mpv, mlaunch, mla, mlc);
            end
        end
    end

    task automatic chk(input string req, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic idle_bus;
        wr_en = 0; rd_en = 0; arr_sel = 0; byte_wr = 0; stop_req = 0;
    endtask

    task automatic awr(input logic [AW-1:0] a, input logic b);
        @(posedge clk); #2;
        wr_en = 1; arr_sel = 1; addr = a; byte_wr = b;
        @(posedge clk); #2;
        idle_bus;
    endtask

    task automatic rwr(input logic [1:0] sel, input logic [7:0] d);
        @(posedge clk); #2;
        wr_en = 1; arr_sel = 0; reg_sel = sel; wdata = d;
        @(posedge clk); #2;
        idle_bus;
    endtask

    task automatic rrd(input logic [1:0] sel);
        @(posedge clk); #2;
        rd_en = 1; arr_sel = 0; reg_sel = sel;
        @(posedge clk); #2;
        idle_bus;
    endtask

    task automatic ard(input logic [AW-1:0] a, input logic exp_inv, input string req);
        @(posedge clk); #2;
        rd_en = 1; arr_sel = 1; addr = a;
        #1 chk(req, rd_invalid, exp_inv);
        @(posedge clk); #2;
        idle_bus;
    endtask

    task automatic seq3(input logic [AW-1:0] a, input logic [7:0] c);
        awr(a, 0);
        rwr(2'd1, c);
        rwr(2'd0, 8'h01);
    endtask

    task automatic clr_all;
        rwr(2'd0, 8'h06);
    endtask

    task automatic wait_done;
        for (int i = 0; i < 100 && !cmd_done; i++) begin
            @(posedge clk); #2;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: got cycle %0d expected under 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        idle_bus;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 buf_empty", buf_empty, 1); chk("R1 cmd_done", cmd_done, 1);
        chk("R1 acc_err", acc_err, 0); chk("R1 prot_viol", prot_viol, 0);
        chk("R1 launch", launch, 0);

        cur_req = "R3";
        awr(12'h100, 0); chk("R3", acc_err, 1);
        clr_all; chk("R13 clear", acc_err, 0);
        div_ready = 1;

        cur_req = "R2";
        seq3(12'h104, C_PROG);
        chk("R2 launch", launch, 1); chk("R2 launch_cmd", launch_cmd == C_PROG, 1);
        chk("R2 launch_addr", launch_addr == 12'h104, 1); chk("R2 busy", cmd_done, 0);
        wait_done; chk("R2 done", cmd_done, 1);

        cur_req = "R4";
        awr(12'h108, 1); chk("R4 byte", acc_err, 1); clr_all;
        awr(12'h109, 0); chk("R4 odd", acc_err, 1); clr_all;

        cur_req = "R6";
        awr(12'h110, 0); awr(12'h112, 0); chk("R6 second word", acc_err, 1); clr_all;
        awr(12'h110, 0); rwr(2'd1, C_PROG); rwr(2'd1, C_PROG); chk("R6 second cmd", acc_err, 1); clr_all;
        awr(12'h110, 0); rwr(2'd1, 8'h99); chk("R6 bad code", acc_err, 1); clr_all;

        cur_req = "R7";
        awr(12'h120, 0); rwr(2'd2, 8'h00); chk("R7 after word", acc_err, 1); clr_all;
        awr(12'h120, 0); rwr(2'd1, C_PROG); rwr(2'd3, 8'h00); chk("R7 after cmd", acc_err, 1); clr_all;
        awr(12'h120, 0); rwr(2'd0, 8'h01); chk("R7 status after word", acc_err, 1); clr_all;

        cur_req = "R8";
        awr(12'h130, 0); rrd(2'd0); rwr(2'd1, C_PROG); rrd(2'd2); ard(12'h130, 0, "R8");
        rwr(2'd0, 8'h01); chk("R8 reads harmless", launch, 1); chk("R8 no err", acc_err, 0);
        wait_done;
        awr(12'h130, 0); rwr(2'd1, C_PROG); rwr(2'd0, 8'h00); chk("R8 go zero", acc_err, 1); clr_all;

        cur_req = "R9";
        secure_en = 1; secure_origin = 0;
        awr(12'h140, 0); rwr(2'd1, C_PROG); chk("R9 untrusted", acc_err, 1); clr_all;
        seq3(12'h140, C_MASS); chk("R9 mass ok", launch, 1); wait_done;
        secure_origin = 1;
        seq3(12'h140, C_PROG); chk("R9 trusted", launch, 1); wait_done;
        secure_en = 0; secure_origin = 0;

        cur_req = "R11";
        prot_en = 4'b0010;
        awr(12'h400, 0); rwr(2'd1, C_PROG); chk("R11 prog", prot_viol, 1);
        rwr(2'd0, 8'h04); chk("R13 wrong clear bit", prot_viol, 1);
        rwr(2'd0, 8'h02); chk("R13 pv clear", prot_viol, 0);
        awr(12'h402, 0); rwr(2'd1, C_SECT); chk("R11 sect", prot_viol, 1); clr_all;
        awr(12'h000, 0); rwr(2'd1, C_MASS); chk("R11 mass", prot_viol, 1); clr_all;
        seq3(12'h000, C_PROG); chk("R11 open region", launch, 1); wait_done;
        prot_en = '0;

        cur_req = "R5";
        seq3(12'h010, C_COMP); awr(12'h012, 0); chk("R5 compress", acc_err, 1); clr_all; wait_done;
        cur_req = "R10";
        seq3(12'h010, C_SECT); seq3(12'h010, C_ABORT); chk("R10 abort hit", acc_err, 1);
        clr_all;
        cur_req = "R5";
        awr(12'h014, 0); chk("R5 abort active", acc_err, 1); clr_all; wait_done;

        cur_req = "R14";
        seq3(12'h020, C_PROG); seq3(12'h030, C_SECT); chk("R14 waiting", buf_empty, 0);
        awr(12'h040, 0); rwr(2'd1, C_PROG); rwr(2'd0, 8'h01); chk("R14 full ignores", launch, 0);
        cur_req = "R10";
        @(posedge clk); #2 stop_req = 1; @(posedge clk); #2 stop_req = 0;
        chk("R10 stop err", acc_err, 1); chk("R10 stop done", cmd_done, 1); chk("R10 purge", buf_empty, 1);
        clr_all;

        cur_req = "R12";
        seq3(12'h050, C_PROG); ard(12'h050, 1, "R12 busy read"); chk("R12 no flag", acc_err, 0);
        wait_done; ard(12'h050, 0, "R12 idle read");

        cur_req = "R13";
        awr(12'h060, 1); awr(12'h062, 0); clr_all;
        rwr(2'd1, C_PROG); rwr(2'd0, 8'h01); chk("R13 ignored word", launch, 0);
        chk("R13 idle", cmd_done, 1);

        cur_req = "R14";
        seq3(12'h070, C_PROG); seq3(12'h072, C_PROG); chk("R14 queued", buf_empty, 0);
        wait_done; chk("R14 drained", cmd_done, 1);

        repeat (3) @(posedge clk);
        #2 finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule